// File: doc/BRIEF.md
# Non-Revertive Reference Auto-Switch Controller

This block decides which of two reference clocks feeds a downstream clock multiplexer. It watches three control inputs: a manual select bit, an auto-mode enable, and the loss-of-lock flag from the PLL. It drives the multiplexer select, and it drives an acknowledge output that always reports the reference in use.

With auto mode off, the manual bit steers the multiplexer directly. With auto mode on and the PLL locked, the block arms and holds the reference chosen by the manual bit at that moment. A loss-of-lock while armed moves the selection to the other reference, and this happens once only. The selection stays there, and the manual bit is ignored, until auto mode is dropped and raised again.

All three inputs may be asynchronous to the block clock. Each one passes through a configurable flip-flop synchronizer before any decision is made on it.

Top module: `refsw_ctrl`

## Requirements
- R1: While auto mode is 0, the select follows the manual bit: 0 selects reference 0, 1 selects reference 1.
- R2: Arming happens only when auto mode is 1 and loss-of-lock is 0. The manual bit at that moment becomes the initial reference, and it is held while armed even if the manual bit later changes.
- R3: While armed, a loss-of-lock value of 1 switches the select to the other reference.
- R4: At most one automatic switch is made per arming. Loss-of-lock that stays high, or that toggles, after the switch does not change the select again.
- R5: After an automatic switch, the manual bit has no effect on the select while auto mode stays 1.
- R6: Re-arming requires auto mode to go to 0 and then back to 1 with loss-of-lock 0. On auto mode going to 0, the select returns to following the manual bit.
- R7: The acknowledge output equals the multiplexer select on every cycle: 0 for reference 0, 1 for reference 1.
- R8: If auto mode is 1 while loss-of-lock is 1 and the block is unarmed, the select keeps following the manual bit. The block arms once loss-of-lock falls.
- R9: Asynchronous reset selects reference 0 and leaves the block unarmed.
- R10: Each input passes through SYNC_STAGES flip-flops (default 2). An input change made between two clock edges shows at the outputs after exactly SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| man_sel_i | input | 1 | Manual reference choice, asynchronous |
| auto_en_i | input | 1 | Auto mode enable, asynchronous |
| lol_i | input | 1 | PLL loss-of-lock flag, asynchronous |
| mux_sel_o | output | 1 | Select for the reference multiplexer |
| ref_ack_o | output | 1 | Acknowledge of the active reference |

## Verification
The bench raises auto mode while lock is absent. A design that arms too early would switch on that first loss-of-lock instead of tracking the manual bit.

After a switch, the bench toggles loss-of-lock several times. A design that re-arms on its own would flip back and forth.

The bench also moves the manual bit while the block is armed and again after a switch. A design that leaks the manual bit into auto mode would change the select without any lock event.

Finally, the bench times a single input edge against the synchronizer depth. A missing or extra stage would shift the output change by one cycle.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic [1:0] {
    SW_TRACK = 2'd0,
    SW_ARMED = 2'd1,
    SW_SPENT = 2'd2
  } sw_state_e;
endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
  import refsw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      man_sel_i,
  input  logic      auto_en_i,
  input  logic      lol_i,
  output sw_state_e state_o,
  output logic      sel_o
);
  sw_state_e state_q, state_d;
  logic      sel_q, sel_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      SW_TRACK: begin
        sel_d = man_sel_i;
        if (auto_en_i && !lol_i) state_d = SW_ARMED;
      end
      SW_ARMED: begin
        if (!auto_en_i) begin
          state_d = SW_TRACK;
          sel_d   = man_sel_i;
        end else if (lol_i) begin
          // armed implies lock was seen, so a high flag here is a fault edge
          state_d = SW_SPENT;
          sel_d   = ~sel_q;
        end
      end
      SW_SPENT: begin
        if (!auto_en_i) begin
          state_d = SW_TRACK;
          sel_d   = man_sel_i;
        end
      end
      default: begin
        state_d = SW_TRACK;
        sel_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= SW_TRACK;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end

  assign state_o = state_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic man_sel_i,
  input  logic auto_en_i,
  input  logic lol_i,
  output logic mux_sel_o,
  output logic ref_ack_o
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              s_sel, s_auto, s_lol;
  sw_state_e         state;
  logic              sel;

  assign raw_in = {lol_i, auto_en_i, man_sel_i};

  refsw_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign {s_lol, s_auto, s_sel} = sync_in;

  refsw_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .man_sel_i(s_sel),
    .auto_en_i(s_auto),
    .lol_i    (s_lol),
    .state_o  (state),
    .sel_o    (sel)
  );

  assign mux_sel_o = sel;
  assign ref_ack_o = sel;
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk
  import refsw_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      s_sel,
  input logic      s_auto,
  input logic      s_lol,
  input sw_state_e state,
  input logic      mux_sel_o,
  input logic      ref_ack_o
);
  a_r7_ack_matches_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o == mux_sel_o);

  a_r1_track_follows_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_TRACK) |=> (mux_sel_o == $past(s_sel)));

  a_r2_arm_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_ARMED && $past(state) != SW_ARMED) |-> $past(s_auto && !s_lol));

  a_r2_armed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_ARMED && s_auto && !s_lol) |=> $stable(mux_sel_o));

  a_r3_fault_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_ARMED && s_auto && s_lol) |=> (mux_sel_o != $past(mux_sel_o)));

  a_r4_single_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_SPENT && s_auto) |=> $stable(mux_sel_o));

  a_r6_rearm_via_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SW_ARMED && $past(state) != SW_ARMED) |-> ($past(state) == SW_TRACK));
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .s_sel    (s_sel),
  .s_auto   (s_auto),
  .s_lol    (s_lol),
  .state    (state),
  .mux_sel_o(mux_sel_o),
  .ref_ack_o(ref_ack_o)
);

// File: tb/sim_refsw_ctrl.sv
module sim_refsw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic man_sel = 1'b0, auto_en = 1'b0, lol = 1'b0;
  logic mux_sel, ref_ack;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R9";
  bit done = 0;

  // behavioural model: queued input history, mode 0=tracking,1=armed,2=spent
  int q_sel[$], q_auto[$], q_lol[$];
  int m_mode = 0, m_sel = 0;

  refsw_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .man_sel_i(man_sel), .auto_en_i(auto_en),
    .lol_i(lol), .mux_sel_o(mux_sel), .ref_ack_o(ref_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_reset();
    q_sel.delete(); q_auto.delete(); q_lol.delete();
    for (int i = 0; i < SYNC; i++) begin
      q_sel.push_back(0); q_auto.push_back(0); q_lol.push_back(0);
    end
    m_mode = 0; m_sel = 0;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      int ds, da, dl;
      ds = q_sel.pop_front(); da = q_auto.pop_front(); dl = q_lol.pop_front();
      q_sel.push_back(int'(man_sel)); q_auto.push_back(int'(auto_en)); q_lol.push_back(int'(lol));
      if (m_mode == 0) begin
        m_sel = ds;
        if (da == 1 && dl == 0) m_mode = 1;
      end else if (da == 0) begin
        m_mode = 0; m_sel = ds;
      end else if (m_mode == 1 && dl == 1) begin
        m_mode = 2; m_sel = 1 - m_sel;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus R7 ack check
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(cur_req, int'(mux_sel), m_sel);
      chk("R7", int'(ref_ack), int'(mux_sel));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    finish_run();
  end

  initial begin
    model_reset();
    step(3);
    chk("R9", int'(mux_sel), 0);
    rst_ni = 1'b1;
    step(2);
    chk("R9", int'(ref_ack), 0);

    // R1 manual tracking, R10 latency
    cur_req = "R1";
    @(negedge clk); man_sel = 1'b1;
    step(2); chk("R10", int'(mux_sel), 0);
    step(1); chk("R10", int'(mux_sel), 1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); man_sel = ~man_sel; end
    step(5); chk("R1", int'(mux_sel), int'(man_sel));

    // R8 auto with lol high stays tracking
    cur_req = "R8";
    @(negedge clk); lol = 1'b1; auto_en = 1'b1;
    step(4);
    @(negedge clk); man_sel = 1'b0;
    step(4); chk("R8", int'(mux_sel), 0);
    @(negedge clk); man_sel = 1'b1;
    step(4); chk("R8", int'(mux_sel), 1);
    @(negedge clk); lol = 1'b0;  // arms with ref 1
    step(5);

    // R2 armed holds
    cur_req = "R2";
    @(negedge clk); man_sel = 1'b0;
    step(5); chk("R2", int'(mux_sel), 1);

    // R3 switch
    cur_req = "R3";
    @(negedge clk); lol = 1'b1;
    step(3); chk("R3", int'(mux_sel), 0);

    // R4 lol toggling, R5 manual ignored
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin @(negedge clk); lol = ~lol; end
    step(4); chk("R4", int'(mux_sel), 0);
    cur_req = "R5";
    @(negedge clk); lol = 1'b0; man_sel = 1'b1;
    step(5); chk("R5", int'(mux_sel), 0);
    @(negedge clk); man_sel = 1'b0;
    step(3);
    @(negedge clk); man_sel = 1'b1;
    step(5); chk("R5", int'(mux_sel), 0);

    // R6 leave auto, follow manual, re-arm on ref 1 then fault
    cur_req = "R6";
    @(negedge clk); auto_en = 1'b0;
    step(4); chk("R6", int'(mux_sel), 1);
    @(negedge clk); auto_en = 1'b1;
    step(5); chk("R6", int'(mux_sel), 1);
    @(negedge clk); lol = 1'b1;
    step(4); chk("R6", int'(mux_sel), 0);
    @(negedge clk); lol = 1'b0;
    step(5); chk("R4", int'(mux_sel), 0);

    // R9 reset mid-run
    cur_req = "R9";
    @(negedge clk); rst_ni = 1'b0; auto_en = 1'b0; man_sel = 1'b0;
    #1 chk("R9", int'(mux_sel), 0);
    step(2); rst_ni = 1'b1;
    step(4); chk("R9", int'(mux_sel), 0);
    finish_run();
  end
endmodule